// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block is a memory-mapped machine timer for a small multi-hart system. It keeps a single 64-bit time counter that all harts share. It also keeps one 64-bit compare register for each hart and drives one level-sensitive timer interrupt line per hart. The counter advances by one on every cycle where the timebase tick enable is high. Software can overwrite the counter at any time, as a full 64-bit word or one 32-bit half at a time.

A simple single-cycle register bus gives access to the compare array and to the counter. Each access is either 32 or 64 bits wide. A 32-bit access always carries its data in bits 31:0 of the data buses. A 32-bit write to one half of a 64-bit register keeps the other half, so a 32-bit host can build a full value in two writes. Each hart's interrupt is the registered result of the comparison "compare <= time". Writing a compare value that is already in the past therefore raises the line on the next cycle. Writing the counter re-evaluates every hart in the same way.

Accesses that hit no legal register read as zero and change nothing. They also set a sticky error flag, which only reset clears.

Top module: `htc_top`

## Requirements
- R1: Hart i's compare register sits at byte address CMP_BASE + 8*i (default CMP_BASE = 0x0000, NUM_HARTS = 4). An address at or beyond CMP_BASE + 8*NUM_HARTS is unmapped.
- R2: A 32-bit compare write at slot offset +0 replaces bits 31:0 and keeps bits 63:32. At offset +4 it replaces bits 63:32 and keeps bits 31:0. In both cases the data is taken from wdata[31:0].
- R3: A 64-bit compare write at offset +0 replaces all 64 bits, and a 64-bit read there returns all 64 bits. A 32-bit read returns the low half (offset +0) or the high half (offset +4), zero-extended in rdata.
- R4: irq_o[i] is high exactly when compare[i] <= time held one cycle earlier. The line therefore changes one cycle after the register update, including straight after a write of a value already in the past.
- R5: The time counter sits at TIME_BASE (default 0x0100). A 64-bit access at +0 reads or writes the whole counter. A 32-bit access at +0 or +4 reads or writes the low or high half, and a 32-bit write keeps the other half.
- R6: A 64-bit access at offset +4 of the counter or of a compare slot is illegal. A write there changes no register.
- R7: With tick_en high the counter increases by one per cycle. A software write to the counter in the same cycle wins over the increment.
- R8: Reset sets the counter and every compare register to zero, and clears the error flag. Every irq_o bit is high right after reset.
- R9: An unmapped address, a byte offset other than 0 or 4 inside a slot, or an illegal width reads as zero, is ignored on write, and sets err_o. Once set, err_o stays high until reset.
- R10: After any write to the counter, every hart's interrupt is re-evaluated against the new time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase tick; the counter advances on each cycle it is high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| bus_rdata | output | 64 | Combinational read data for bus_addr / bus_wide |
| irq_o | output | NUM_HARTS (4) | Per-hart timer interrupt, registered |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
On every cycle, the bound checker checks several things. Each interrupt must equal the previous cycle's comparison. The counter must step by one under tick, unless a software write overrides it. A 32-bit low-half counter write must keep the high half. An illegal write must leave all registers unchanged. The error flag must stay set once raised. Some behaviour can only be shown by the bench scenarios. These include address placement across slots and the half-word merge results read back from the compare array. They also include re-evaluating several harts at once after a counter write, and a past-valued compare raising its line on the cycle after it is written.

// File: rtl/htc_pkg.sv
// Shared types and helpers for the hart timer comparator.
// Assumes 32-bit data always travels in bits 31:0 of the bus.
package htc_pkg;

    typedef enum logic [2:0] {
        ACC_BAD       = 3'd0,
        ACC_CMP_LO    = 3'd1,
        ACC_CMP_HI    = 3'd2,
        ACC_CMP_FULL  = 3'd3,
        ACC_TIME_LO   = 3'd4,
        ACC_TIME_HI   = 3'd5,
        ACC_TIME_FULL = 3'd6
    } acc_kind_e;

    // Replace one 32-bit half of a 64-bit word, keeping the other half.
    function automatic logic [63:0] merge_half(input logic [63:0] cur,
                                               input logic [31:0] wd,
                                               input logic        hi);
        return hi ? {wd, cur[31:0]} : {cur[63:32], wd};
    endfunction

endpackage

// File: rtl/htc_decode.sv
// Address decoder: classifies one bus access as a compare slot half or
// full word, a time counter half or full word, or illegal.
// Assumes CMP_BASE and TIME_BASE are 8-byte aligned and their windows do
// not overlap.
module htc_decode
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 4,
    parameter int SLOT_W    = 2,
    parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE = ADDR_W'(16'h0100)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output acc_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [ADDR_W-1:0] CMP_SPAN  = ADDR_W'(8 * NUM_HARTS);
    localparam logic [ADDR_W-1:0] TIME_HI_A = TIME_BASE + ADDR_W'(4);

    logic [ADDR_W-1:0] cmp_off;

    // Offset into the compare window; wraps high for addresses below it.
    always_comb cmp_off = addr - CMP_BASE;

    // Classify the access by region, byte offset and width.
    always_comb begin
        kind = ACC_BAD;
        slot = cmp_off[3 +: SLOT_W];
        if (cmp_off < CMP_SPAN) begin
            if (cmp_off[2:0] == 3'd0)
                kind = wide ? ACC_CMP_FULL : ACC_CMP_LO;
            else if (cmp_off[2:0] == 3'd4 && !wide)
                kind = ACC_CMP_HI;
        end else if (addr == TIME_BASE) begin
            kind = wide ? ACC_TIME_FULL : ACC_TIME_LO;
        end else if (addr == TIME_HI_A && !wide) begin
            kind = ACC_TIME_HI;
        end
    end

endmodule

// File: rtl/htc_time.sv
// Shared 64-bit time counter. It steps on tick and can be loaded by
// software in full or by half; a load wins over the step.
module htc_time
    import htc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        wr_full,
    input  logic [63:0] wdata,
    output logic [63:0] time_q
);
    // Counter register: reset to zero, load on write, else step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            time_q <= '0;
        else if (wr_full)      time_q <= wdata;
        else if (wr_lo)        time_q <= merge_half(time_q, wdata[31:0], 1'b0);
        else if (wr_hi)        time_q <= merge_half(time_q, wdata[31:0], 1'b1);
        else if (tick)         time_q <= time_q + 64'd1;
    end

endmodule

// File: rtl/htc_cmp_slot.sv
// One hart's compare register and its registered interrupt line.
// The line reflects "compare <= time" with one cycle of latency.
module htc_cmp_slot
    import htc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        wr_full,
    input  logic [63:0] wdata,
    input  logic [63:0] time_q,
    output logic [63:0] cmp_q,
    output logic        irq_q
);
    // Compare register: reset to zero, full or half-word update.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_q <= '0;
        else if (wr_full) cmp_q <= wdata;
        else if (wr_lo)   cmp_q <= merge_half(cmp_q, wdata[31:0], 1'b0);
        else if (wr_hi)   cmp_q <= merge_half(cmp_q, wdata[31:0], 1'b1);
    end

    // Interrupt register: high after reset since both values are zero.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= (cmp_q <= time_q);
    end

endmodule

// File: rtl/htc_top.sv
// Multi-hart machine timer comparator top level.
// Assumes NUM_HARTS <= MAX_HARTS and 8-byte aligned base offsets; reads are
// combinational, writes take effect at the next clock edge.
module htc_top
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_HARTS = 16,
    parameter int NUM_HARTS = 4,
    parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE = ADDR_W'(16'h0100)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic                 bus_wide,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] irq_o,
    output logic                 err_o
);
    localparam int SLOT_W = (MAX_HARTS > 1 && NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    acc_kind_e                  acc_kind;
    logic [SLOT_W-1:0]          acc_slot;
    logic                       wr_go;
    logic [63:0]                time_q;
    logic [NUM_HARTS-1:0][63:0] cmp_all;
    logic [63:0]                cmp_sel;

    htc_decode #(
        .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .SLOT_W(SLOT_W),
        .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
    ) u_dec (
        .addr(bus_addr), .wide(bus_wide), .kind(acc_kind), .slot(acc_slot)
    );

    // Write strobe qualified by request.
    always_comb wr_go = bus_valid && bus_write;

    htc_time u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .wr_lo(wr_go && acc_kind == ACC_TIME_LO),
        .wr_hi(wr_go && acc_kind == ACC_TIME_HI),
        .wr_full(wr_go && acc_kind == ACC_TIME_FULL),
        .wdata(bus_wdata), .time_q(time_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic hit;
        // Slot select for this hart.
        always_comb hit = wr_go && (acc_slot == SLOT_W'(h));
        htc_cmp_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(hit && acc_kind == ACC_CMP_LO),
            .wr_hi(hit && acc_kind == ACC_CMP_HI),
            .wr_full(hit && acc_kind == ACC_CMP_FULL),
            .wdata(bus_wdata), .time_q(time_q),
            .cmp_q(cmp_all[h]), .irq_q(irq_o[h])
        );
    end

    // Compare word addressed by the current slot.
    always_comb cmp_sel = cmp_all[acc_slot];

    // Read mux: halves zero-extended, illegal accesses read zero.
    always_comb begin
        case (acc_kind)
            ACC_CMP_LO:    bus_rdata = {32'd0, cmp_sel[31:0]};
            ACC_CMP_HI:    bus_rdata = {32'd0, cmp_sel[63:32]};
            ACC_CMP_FULL:  bus_rdata = cmp_sel;
            ACC_TIME_LO:   bus_rdata = {32'd0, time_q[31:0]};
            ACC_TIME_HI:   bus_rdata = {32'd0, time_q[63:32]};
            ACC_TIME_FULL: bus_rdata = time_q;
            default:       bus_rdata = '0;
        endcase
    end

    // Sticky error flag for any illegal access.
    always_ff @(posedge clk) begin
        if (!rst_n)                              err_o <= 1'b0;
        else if (bus_valid && acc_kind == ACC_BAD) err_o <= 1'b1;
    end

endmodule

// File: rtl/htc_checker.sv
// Cycle-by-cycle properties of the timer comparator, bound to htc_top.
module htc_checker
    import htc_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [63:0]                bus_wdata,
    input  logic [63:0]                bus_rdata,
    input  acc_kind_e                  acc_kind,
    input  logic [63:0]                time_q,
    input  logic [NUM_HARTS-1:0][63:0] cmp_all,
    input  logic [NUM_HARTS-1:0]       irq_o,
    input  logic                       err_o
);
    logic time_wr;
    // Any software write to the counter this cycle.
    always_comb time_wr = bus_valid && bus_write &&
        (acc_kind == ACC_TIME_LO || acc_kind == ACC_TIME_HI || acc_kind == ACC_TIME_FULL);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
        p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq_o[h] == ($past(cmp_all[h]) <= $past(time_q)));
    end

    p_tick_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && !time_wr |=> time_q == $past(time_q) + 64'd1);

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && acc_kind == ACC_TIME_FULL |=> time_q == $past(bus_wdata));

    p_lo_keeps_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && acc_kind == ACC_TIME_LO
        |=> time_q[63:32] == $past(time_q[63:32]) && time_q[31:0] == $past(bus_wdata[31:0]));

    p_bad_noeffect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && acc_kind == ACC_BAD && !tick_en
        |=> $stable(time_q) && $stable(cmp_all));

    p_bad_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && acc_kind == ACC_BAD |-> bus_rdata == 64'd0);

    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && acc_kind == ACC_BAD |=> err_o);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind htc_top htc_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_kind(acc_kind), .time_q(time_q), .cmp_all(cmp_all),
    .irq_o(irq_o), .err_o(err_o)
);

// File: tb/sim_htc_top.sv
// Self-checking bench for htc_top: a vector table, then directed tests.
module sim_htc_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] MAXV = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [15:0] addr;
        logic [63:0] wdata;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 16'h0000, 64'h1111_2222_3333_4444, 64'h0, 8'd3},  // R3 full write
        '{1'b0, 1'b1, 16'h0000, 64'h0, 64'h1111_2222_3333_4444, 8'd3},  // R3 full read
        '{1'b1, 1'b0, 16'h0004, 64'hAAAA_BBBB, 64'h0, 8'd2},            // R2 hi half
        '{1'b0, 1'b1, 16'h0000, 64'h0, 64'hAAAA_BBBB_3333_4444, 8'd2},  // R2
        '{1'b1, 1'b0, 16'h0000, 64'h5555_6666, 64'h0, 8'd2},            // R2 lo half
        '{1'b0, 1'b0, 16'h0000, 64'h0, 64'h5555_6666, 8'd3},            // R3 lo read
        '{1'b0, 1'b0, 16'h0004, 64'h0, 64'hAAAA_BBBB, 8'd3},            // R3 hi read
        '{1'b1, 1'b1, 16'h0018, 64'h77, 64'h0, 8'd1},                   // R1 hart 3
        '{1'b0, 1'b1, 16'h0018, 64'h0, 64'h77, 8'd1},                   // R1
        '{1'b0, 1'b1, 16'h0008, 64'h0, 64'h0, 8'd1},                    // R1 hart 1 untouched
        '{1'b0, 1'b1, 16'h0020, 64'h0, 64'h0, 8'd9},                    // R9 beyond array
        '{1'b0, 1'b0, 16'h0003, 64'h0, 64'h0, 8'd9},                    // R9 odd offset
        '{1'b1, 1'b1, 16'h0100, 64'h1_0000_0000, 64'h0, 8'd5},          // R5 full time
        '{1'b0, 1'b0, 16'h0104, 64'h0, 64'h1, 8'd5},                    // R5 hi read
        '{1'b1, 1'b0, 16'h0100, 64'h10, 64'h0, 8'd5},                   // R5 lo merge
        '{1'b0, 1'b1, 16'h0100, 64'h0, 64'h1_0000_0010, 8'd5},          // R5
        '{1'b1, 1'b1, 16'h0104, 64'hFF, 64'h0, 8'd6},                   // R6 illegal
        '{1'b0, 1'b1, 16'h0100, 64'h0, 64'h1_0000_0010, 8'd6}           // R6 unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_wide = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [3:0]  irq_o;
    logic        err_o;
    int          n_run = 0;
    int          n_fail = 0;
    logic [63:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    htc_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_wide(bus_wide), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write applied at the next posedge; returns at the following negedge.
    task automatic wr(input logic wide, input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Combinational read sampled inside the low phase.
    task automatic rdv(input logic wide, input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_wide = wide; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 irq after reset", 64'(irq_o), 64'hF);
        check("R8 err after reset", 64'(err_o), 64'h0);
        rdv(1'b1, 16'h0100, rd); check("R8 time zero", rd, 64'h0);
        rdv(1'b1, 16'h0010, rd); check("R8 cmp2 zero", rd, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].wide, VECS[i].addr, VECS[i].wdata);
            else begin
                rdv(VECS[i].wide, VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end
        check("R9 err sticky", 64'(err_o), 64'h1);

        // R6: 64-bit write at compare +4 leaves slot untouched
        wr(1'b1, 16'h0004, 64'hDEAD);
        rdv(1'b1, 16'h0000, rd); check("R6 cmp0 unchanged", rd, 64'hAAAA_BBBB_5555_6666);

        // R4 / R10: interrupt pattern and counter-write re-evaluation
        wr(1'b1, 16'h0000, 64'd200);
        wr(1'b1, 16'h0008, 64'd50);
        wr(1'b1, 16'h0010, 64'd100);
        wr(1'b1, 16'h0018, MAXV);
        wr(1'b1, 16'h0100, 64'd100);
        @(negedge clk);
        check("R4 irq pattern", 64'(irq_o), 64'h6);
        wr(1'b0, 16'h0100, 64'd300);
        check("R4 one-cycle latency", 64'(irq_o), 64'h6);
        @(negedge clk);
        check("R10 re-evaluate all harts", 64'(irq_o), 64'h7);
        wr(1'b1, 16'h0018, 64'd5);
        @(negedge clk);
        check("R4 past compare raises", 64'(irq_o), 64'hF);

        // R7: tick counting and write priority
        wr(1'b1, 16'h0000, 64'd1003);
        wr(1'b1, 16'h0008, MAXV);
        wr(1'b1, 16'h0010, MAXV);
        wr(1'b1, 16'h0018, MAXV);
        wr(1'b1, 16'h0100, 64'd1000);
        @(negedge clk);
        check("R4 no irq before tick", 64'(irq_o), 64'h0);
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
        check("R7 irq after ticks", 64'(irq_o), 64'h1);
        rdv(1'b1, 16'h0100, rd); check("R7 three ticks", rd, 64'd1003);
        @(negedge clk);
        tick_en = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_wide = 1'b1;
        bus_addr = 16'h0100; bus_wdata = 64'd50;
        @(negedge clk);
        tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        rdv(1'b1, 16'h0100, rd); check("R7 write wins over tick", rd, 64'd50);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule